// File: doc/BRIEF.md
# PCI Bus Master Sequencer

This block is the initiator-side control for a 32-bit PCI bus master. The local side supplies a start address, a direction, a word count and the write data. The block requests the bus from the arbiter on its own request line and waits for a grant while the bus is idle. It then issues the address and a memory read or memory write command. It runs the data phases against the target's ready, select and stop inputs, and it releases the frame signal for the final phase.

Write data is taken from the local port in the cycle it is driven onto the bus. The local side should present the word that belongs to `next_addr_o`. Read words appear on `rd_data_o`, qualified by `rd_valid_o` in the cycle they complete. When the transfer finishes, `done_o` pulses and `status_o` reports one of three results: normal completion, ended by the target, or no target responded. After a target-ended transfer, `rem_count_o` and `next_addr_o` keep the unfinished part, so the local side can issue the rest again. Bus locking is never used.

Top module: `pci_mst_seq`

## Requirements
- R1: While reset is applied and after it is released, `req_n_o`, `frame_n_o` and `irdy_n_o` are high, and `ctl_oe_o`, `ad_oe_o`, `busy_o` and `done_o` are low.
- R2: When `start_i` is sampled high in idle with a nonzero `count_i`, `req_n_o` goes low in the next cycle and `busy_o` goes high. A start with `count_i` zero is ignored: `req_n_o` stays high, `busy_o` stays low, and `rem_count_o` and `next_addr_o` keep their values.
- R3: The address phase starts in the cycle after an edge at which `gnt_n_i` was low and both `frame_n_i` and `irdy_n_i` were high while requesting. Until then `frame_n_o` stays high. `req_n_o` is high throughout the address phase.
- R4: In the address phase `frame_n_o` is low, `irdy_n_o` is high, `ad_oe_o` is high and `ad_o` carries the start address. `cbe_n_o` carries the command: 4'b0111 for a write and 4'b0110 for a read.
- R5: In every data phase `irdy_n_o` is low and `cbe_n_o` is 4'b0000. On a write, `ad_oe_o` is high and `ad_o` equals `wr_data_i`. On a read, `ad_oe_o` is low.
- R6: A word completes only at an edge where `irdy_n_o`, `trdy_n_i` and `devsel_n_i` are all low. Otherwise the phase waits. At completion, `rem_count_o` drops by one and `next_addr_o` rises by 4. On a read, `rd_valid_o` is high in that cycle and `rd_data_o` equals `ad_i`.
- R7: With no stop and no abort, `frame_n_o` is high in exactly the final data phase. That is the phase of word `count_i`-1, and it is the first data phase when the count is 1.
- R8: A `stop_n_i` sampled low together with `devsel_n_i` low makes the next data phase the final one, with `frame_n_o` high. The transfer ends after that phase. If `frame_n_o` is already high, the transfer ends at that edge. The status is 1, and `rem_count_o` and `next_addr_o` count only the completed words.
- R9: If `devsel_n_i` is not sampled low in the first five data-phase cycles, the transfer ends with status 2. A final phase with `frame_n_o` high is added when `frame_n_o` was still low. This gives 5 `irdy_n_o`-low cycles for a count of 1, and 6 for a larger count.
- R10: After the final phase there is exactly one cycle with `frame_n_o` and `irdy_n_o` high and `ctl_oe_o` high. In that cycle `done_o` is high and `status_o` is valid. In the following cycle `busy_o` and `done_o` are low.
- R11: A transfer in which all words complete ends with status 0 and `rem_count_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a transfer (sampled in idle) |
| addr_i | input | 32 | Start byte address |
| write_i | input | 1 | 1 = write, 0 = read |
| count_i | input | CNT_W | Number of words |
| wr_data_i | input | 32 | Write word for `next_addr_o` |
| rd_data_o | output | 32 | Read word |
| rd_valid_o | output | 1 | Read word completes this cycle |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished (turnaround cycle) |
| status_o | output | 2 | 0 complete, 1 target stop, 2 no target |
| rem_count_o | output | CNT_W | Words not yet transferred |
| next_addr_o | output | 32 | Address of the next word |
| req_n_o | output | 1 | Bus request to arbiter, active low |
| gnt_n_i | input | 1 | Bus grant from arbiter, active low |
| frame_n_i | input | 1 | Sampled bus frame, active low |
| irdy_n_i | input | 1 | Sampled bus initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| devsel_n_i | input | 1 | Target selected, active low |
| stop_n_i | input | 1 | Target stop request, active low |
| ad_i | input | 32 | Sampled address/data bus |
| ad_o | output | 32 | Driven address/data |
| ad_oe_o | output | 1 | Enable for `ad_o` |
| cbe_n_o | output | 4 | Command / byte enables, active low |
| frame_n_o | output | 1 | Driven frame, active low |
| irdy_n_o | output | 1 | Driven initiator ready, active low |
| ctl_oe_o | output | 1 | Enable for frame, ready and command lines |

## Verification
The request line is due one cycle after the start edge, and the address phase one cycle after the edge that sees a grant on an idle bus. The first data phase follows in the next cycle. `rd_valid_o` and a write word on `ad_o` belong to the same cycle as the target's ready. The counters move at the completing edge, and `done_o` is due in the cycle after the final phase. The bench drives the target inputs at the falling edge and reads combinational results 1 ns later. It reads registered results at the following falling edge, so every check falls in the cycle its result is due.

// File: rtl/pci_mst_pkg.sv
package pci_mst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA,
    ST_TURN
  } mst_state_e;

  typedef enum logic [1:0] {
    STS_OK     = 2'd0,
    STS_STOP   = 2'd1,
    STS_MABORT = 2'd2
  } mst_status_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/pci_mst_xfer_ctr.sv
module pci_mst_xfer_ctr #(
  parameter int AD_W  = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [AD_W-1:0]  addr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             step_i,
  output logic [AD_W-1:0]  addr_o,
  output logic [CNT_W-1:0] rem_o,
  output logic             rem_one_o,
  output logic             rem_two_o
);
  localparam logic [AD_W-1:0]  STEP = AD_W'(AD_W / 8);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      rem_o  <= '0;
    end else if (load_i) begin
      addr_o <= addr_i;
      rem_o  <= count_i;
    end else if (step_i) begin
      addr_o <= addr_o + STEP;
      rem_o  <= rem_o - ONE;
    end
  end

  assign rem_one_o = (rem_o == ONE);
  assign rem_two_o = (rem_o == TWO);
endmodule

// File: rtl/pci_mst_devsel_tmr.sv
module pci_mst_devsel_tmr #(
  parameter int TMO = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic devsel_n_i,
  output logic expire_o
);
  localparam int TW = (TMO < 2) ? 1 : $clog2(TMO);
  localparam logic [TW-1:0] LAST = TW'(TMO - 1);

  logic [TW-1:0] cnt_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (!devsel_n_i) begin
      seen_q <= 1'b1;
    end else if (!seen_q && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = run_i && !seen_q && devsel_n_i && (cnt_q == LAST);
endmodule

// File: rtl/pci_mst_bus_drv.sv
module pci_mst_bus_drv
  import pci_mst_pkg::*;
#(
  parameter int AD_W = 32
) (
  input  mst_state_e         state_i,
  input  logic               last_i,
  input  logic               write_i,
  input  logic [AD_W-1:0]    addr_i,
  input  logic [AD_W-1:0]    wr_data_i,
  output logic               req_n_o,
  output logic               frame_n_o,
  output logic               irdy_n_o,
  output logic               ctl_oe_o,
  output logic [AD_W-1:0]    ad_o,
  output logic               ad_oe_o,
  output logic [AD_W/8-1:0]  cbe_n_o
);
  logic in_addr, in_data;

  always_comb begin
    in_addr   = (state_i == ST_ADDR);
    in_data   = (state_i == ST_DATA);
    req_n_o   = (state_i != ST_REQ);
    frame_n_o = !(in_addr || (in_data && !last_i));
    irdy_n_o  = !in_data;
    ctl_oe_o  = in_addr || in_data || (state_i == ST_TURN);
    ad_oe_o   = in_addr || (in_data && write_i);
    ad_o      = '0;
    cbe_n_o   = '1;
    if (in_addr) begin
      ad_o    = addr_i;
      cbe_n_o = write_i ? CMD_MEM_WR : CMD_MEM_RD;
    end else if (in_data) begin
      cbe_n_o = '0;
      if (write_i) ad_o = wr_data_i;
    end
  end
endmodule

// File: rtl/pci_mst_seq.sv
module pci_mst_seq
  import pci_mst_pkg::*;
#(
  parameter int AD_W       = 32,
  parameter int CNT_W      = 8,
  parameter int DEVSEL_TMO = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AD_W-1:0]   addr_i,
  input  logic              write_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [AD_W-1:0]   wr_data_i,
  output logic [AD_W-1:0]   rd_data_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [CNT_W-1:0]  rem_count_o,
  output logic [AD_W-1:0]   next_addr_o,
  output logic              req_n_o,
  input  logic              gnt_n_i,
  input  logic              frame_n_i,
  input  logic              irdy_n_i,
  input  logic              trdy_n_i,
  input  logic              devsel_n_i,
  input  logic              stop_n_i,
  input  logic [AD_W-1:0]   ad_i,
  output logic [AD_W-1:0]   ad_o,
  output logic              ad_oe_o,
  output logic [AD_W/8-1:0] cbe_n_o,
  output logic              frame_n_o,
  output logic              irdy_n_o,
  output logic              ctl_oe_o
);
  mst_state_e  state_q;
  mst_status_e status_q;
  logic        last_q, abort_q, write_q;
  logic        rem_one, rem_two;
  logic        in_data, load, xfer_ok, stop_hit, expire, bus_free;

  assign in_data  = (state_q == ST_DATA);
  assign load     = (state_q == ST_IDLE) && start_i && (count_i != '0);
  assign xfer_ok  = in_data && !trdy_n_i && !devsel_n_i;
  assign stop_hit = in_data && !stop_n_i && !devsel_n_i;
  assign bus_free = !gnt_n_i && frame_n_i && irdy_n_i;

  pci_mst_xfer_ctr #(.AD_W(AD_W), .CNT_W(CNT_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .addr_i    (addr_i),
    .count_i   (count_i),
    .step_i    (xfer_ok),
    .addr_o    (next_addr_o),
    .rem_o     (rem_count_o),
    .rem_one_o (rem_one),
    .rem_two_o (rem_two)
  );

  pci_mst_devsel_tmr #(.TMO(DEVSEL_TMO)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (in_data),
    .devsel_n_i (devsel_n_i),
    .expire_o   (expire)
  );

  pci_mst_bus_drv #(.AD_W(AD_W)) u_drv (
    .state_i   (state_q),
    .last_i    (last_q),
    .write_i   (write_q),
    .addr_i    (next_addr_o),
    .wr_data_i (wr_data_i),
    .req_n_o   (req_n_o),
    .frame_n_o (frame_n_o),
    .irdy_n_o  (irdy_n_o),
    .ctl_oe_o  (ctl_oe_o),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .cbe_n_o   (cbe_n_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      status_q <= STS_OK;
      last_q   <= 1'b0;
      abort_q  <= 1'b0;
      write_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          last_q  <= 1'b0;
          abort_q <= 1'b0;
          if (load) begin
            write_q  <= write_i;
            status_q <= STS_OK;
            state_q  <= ST_REQ;
          end
        end
        ST_REQ: if (bus_free) state_q <= ST_ADDR;
        ST_ADDR: begin
          last_q  <= rem_one;
          state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (last_q) begin
            // final phase ends on data, stop or a pending/new abort
            if (xfer_ok || stop_hit || abort_q || expire) begin
              state_q <= ST_TURN;
              if (abort_q || expire)   status_q <= STS_MABORT;
              else if (xfer_ok && rem_one) status_q <= STS_OK;
              else                     status_q <= STS_STOP;
            end
          end else if (expire) begin
            last_q  <= 1'b1;
            abort_q <= 1'b1;
          end else if (stop_hit || (xfer_ok && rem_two)) begin
            last_q <= 1'b1;
          end
        end
        ST_TURN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_TURN);
  assign status_o   = status_q;
  assign rd_valid_o = xfer_ok && !write_q;
  assign rd_data_o  = ad_i;
endmodule

// File: rtl/pci_mst_seq_chk.sv
module pci_mst_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_n_o,
  input logic             gnt_n_i,
  input logic             frame_n_i,
  input logic             irdy_n_i,
  input logic             trdy_n_i,
  input logic             devsel_n_i,
  input logic             stop_n_i,
  input logic             frame_n_o,
  input logic             irdy_n_o,
  input logic             ctl_oe_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             rd_valid_o,
  input logic [CNT_W-1:0] rem_count_o
);
  p_addr_on_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_n_o) |-> $past(!gnt_n_i && frame_n_i && irdy_n_i) && irdy_n_o);

  p_req_off_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_n_o |-> req_n_o);

  p_frame_rise_irdy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_n_o) |-> !irdy_n_o);

  p_wait_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irdy_n_o && trdy_n_i && stop_n_i && !devsel_n_i) |=> !irdy_n_o);

  p_rem_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irdy_n_o && !trdy_n_i && !devsel_n_i) |=>
      rem_count_o == CNT_W'($past(rem_count_o) - 1'b1));

  p_rd_valid_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !irdy_n_o && !trdy_n_i && !devsel_n_i);

  p_turn_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> frame_n_o && irdy_n_o && ctl_oe_o);

  p_idle_after_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o);

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> req_n_o && frame_n_o && irdy_n_o && !ctl_oe_o);
endmodule

bind pci_mst_seq pci_mst_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_n_o     (req_n_o),
  .gnt_n_i     (gnt_n_i),
  .frame_n_i   (frame_n_i),
  .irdy_n_i    (irdy_n_i),
  .trdy_n_i    (trdy_n_i),
  .devsel_n_i  (devsel_n_i),
  .stop_n_i    (stop_n_i),
  .frame_n_o   (frame_n_o),
  .irdy_n_o    (irdy_n_o),
  .ctl_oe_o    (ctl_oe_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rd_valid_o  (rd_valid_o),
  .rem_count_o (rem_count_o)
);

// File: tb/pci_mst_seq_test.sv
`timescale 1ns/1ps
module pci_mst_seq_test;
  localparam int AD_W  = 32;
  localparam int CNT_W = 8;
  localparam logic [31:0] WR_MASK = 32'h5A5A_0000;
  localparam logic [31:0] RD_BASE = 32'hC0DE_0000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic             start_i = 1'b0;
  logic [AD_W-1:0]  addr_i = '0;
  logic             write_i = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic [AD_W-1:0]  wr_data_i;
  logic [AD_W-1:0]  rd_data_o;
  logic             rd_valid_o, busy_o, done_o;
  logic [1:0]       status_o;
  logic [CNT_W-1:0] rem_count_o;
  logic [AD_W-1:0]  next_addr_o;
  logic             req_n_o;
  logic             gnt_n_i = 1'b1, frame_n_i = 1'b1, irdy_n_i = 1'b1;
  logic             trdy_n_i = 1'b1, devsel_n_i = 1'b1, stop_n_i = 1'b1;
  logic [AD_W-1:0]  ad_i = '0;
  logic [AD_W-1:0]  ad_o;
  logic             ad_oe_o;
  logic [3:0]       cbe_n_o;
  logic             frame_n_o, irdy_n_o, ctl_oe_o;

  // local side supplies the word belonging to the current address
  assign wr_data_i = next_addr_o ^ WR_MASK;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  pci_mst_seq #(.AD_W(AD_W), .CNT_W(CNT_W), .DEVSEL_TMO(5)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .write_i(write_i), .count_i(count_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .busy_o(busy_o),
    .done_o(done_o), .status_o(status_o), .rem_count_o(rem_count_o),
    .next_addr_o(next_addr_o), .req_n_o(req_n_o), .gnt_n_i(gnt_n_i),
    .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i), .trdy_n_i(trdy_n_i),
    .devsel_n_i(devsel_n_i), .stop_n_i(stop_n_i), .ad_i(ad_i), .ad_o(ad_o),
    .ad_oe_o(ad_oe_o), .cbe_n_o(cbe_n_o), .frame_n_o(frame_n_o),
    .irdy_n_o(irdy_n_o), .ctl_oe_o(ctl_oe_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // one transfer with a simple target; stop_after < 0 means no stop
  task automatic run_xfer(input bit wr, input logic [31:0] addr, input int cnt,
                          input int waits, input int stop_after, input bit no_dev,
                          input int gnt_delay, input int busy_cyc,
                          input int exp_sts, input int exp_words, input int exp_irdy);
    int words = 0;
    int wctr = 0;
    int irdy_cyc = 0;
    int guard = 0;
    bit stopping = 1'b0;
    @(negedge clk);
    addr_i = addr; write_i = wr; count_i = CNT_W'(cnt); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 req after start", 32'(req_n_o), 32'd0);
    chk("R2 busy after start", 32'(busy_o), 32'd1);
    for (int i = 0; i < gnt_delay + busy_cyc; i++) begin
      gnt_n_i   = (i < gnt_delay);
      frame_n_i = (i < gnt_delay);
      @(negedge clk);
      chk("R3 no frame before idle grant", 32'(frame_n_o), 32'd1);
      chk("R3 req held", 32'(req_n_o), 32'd0);
    end
    gnt_n_i = 1'b0; frame_n_i = 1'b1;
    @(negedge clk);
    gnt_n_i = 1'b1;
    chk("R3 address phase frame", 32'(frame_n_o), 32'd0);
    chk("R3 req released", 32'(req_n_o), 32'd1);
    chk("R4 irdy high", 32'(irdy_n_o), 32'd1);
    chk("R4 ad", ad_o, addr);
    chk("R4 ad_oe", 32'(ad_oe_o), 32'd1);
    chk("R4 command", 32'(cbe_n_o), wr ? 32'h7 : 32'h6);
    @(negedge clk);
    while (!done_o && guard < 200) begin
      guard++;
      if (!irdy_n_o) begin
        irdy_cyc++;
        if (stop_after >= 0 && words == stop_after) stopping = 1'b1;
        devsel_n_i = no_dev;
        stop_n_i   = !stopping;
        trdy_n_i   = no_dev || stopping || (wctr != waits);
        ad_i       = RD_BASE + 32'(words);
        if (stop_after < 0 && !no_dev)
          chk("R7 frame in data", 32'(frame_n_o), 32'(words == cnt - 1));
        chk("R5 cbe data", 32'(cbe_n_o), 32'd0);
        chk("R5 ad_oe data", 32'(ad_oe_o), 32'(wr));
        if (wr) chk("R5 write data", ad_o, (addr + 32'(4 * words)) ^ WR_MASK);
        #1;
        if (!trdy_n_i && !devsel_n_i) begin
          if (!wr) begin
            chk("R6 rd_valid", 32'(rd_valid_o), 32'd1);
            chk("R6 rd_data", rd_data_o, RD_BASE + 32'(words));
          end
          words++;
          wctr = 0;
        end else begin
          chk("R6 no rd_valid in wait", 32'(rd_valid_o), 32'd0);
          wctr++;
        end
      end else begin
        trdy_n_i = 1'b1; devsel_n_i = 1'b1; stop_n_i = 1'b1;
      end
      @(negedge clk);
    end
    trdy_n_i = 1'b1; devsel_n_i = 1'b1; stop_n_i = 1'b1;
    chk("R10 done", 32'(done_o), 32'd1);
    chk("R10 turn frame", 32'(frame_n_o), 32'd1);
    chk("R10 turn irdy", 32'(irdy_n_o), 32'd1);
    chk("R10 turn drive", 32'(ctl_oe_o), 32'd1);
    chk("R11 R8 R9 status", 32'(status_o), 32'(exp_sts));
    chk("R6 words", 32'(words), 32'(exp_words));
    chk("R8 R11 rem", 32'(rem_count_o), 32'(cnt - exp_words));
    chk("R8 next addr", next_addr_o, addr + 32'(4 * exp_words));
    if (exp_irdy >= 0) chk("R9 R6 irdy cycles", 32'(irdy_cyc), 32'(exp_irdy));
    @(negedge clk);
    chk("R10 idle busy", 32'(busy_o), 32'd0);
    chk("R10 idle done", 32'(done_o), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 req in reset", 32'(req_n_o), 32'd1);
    chk("R1 frame in reset", 32'(frame_n_o), 32'd1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 req", 32'(req_n_o), 32'd1);
    chk("R1 frame", 32'(frame_n_o), 32'd1);
    chk("R1 irdy", 32'(irdy_n_o), 32'd1);
    chk("R1 ctl_oe", 32'(ctl_oe_o), 32'd0);
    chk("R1 ad_oe", 32'(ad_oe_o), 32'd0);
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 done", 32'(done_o), 32'd0);
  endtask

  task automatic t_write_burst;
    run_xfer(1'b1, 32'h1000_0000, 4, 0, -1, 1'b0, 2, 2, 0, 4, 4);
  endtask

  task automatic t_read_waits;
    run_xfer(1'b0, 32'h2000_0040, 3, 1, -1, 1'b0, 0, 0, 0, 3, 6);
  endtask

  task automatic t_single;
    run_xfer(1'b1, 32'h3000_0100, 1, 0, -1, 1'b0, 1, 0, 0, 1, 1);
    run_xfer(1'b0, 32'h3000_0200, 1, 2, -1, 1'b0, 0, 1, 0, 1, 3);
  endtask

  task automatic t_stop_reissue;
    logic [31:0] a;
    int r;
    // R8: stop after two words, then issue the rest from the kept state
    run_xfer(1'b1, 32'h4000_0000, 6, 0, 2, 1'b0, 0, 0, 1, 2, 4);
    a = next_addr_o;
    r = int'(rem_count_o);
    chk("R8 kept addr", a, 32'h4000_0008);
    run_xfer(1'b1, a, r, 0, -1, 1'b0, 0, 0, 0, 4, 4);
    chk("R8 reissue end addr", next_addr_o, 32'h4000_0018);
  endtask

  task automatic t_stop_last;
    run_xfer(1'b0, 32'h5000_0000, 1, 0, 0, 1'b0, 0, 0, 1, 0, 1);
  endtask

  task automatic t_zero_count;
    logic [31:0] a;
    logic [CNT_W-1:0] r;
    a = next_addr_o;
    r = rem_count_o;
    @(negedge clk);
    addr_i = 32'h7777_0000; count_i = '0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 zero count no req", 32'(req_n_o), 32'd1);
    chk("R2 zero count not busy", 32'(busy_o), 32'd0);
    chk("R2 zero count rem kept", 32'(rem_count_o), 32'(r));
    chk("R2 zero count addr kept", next_addr_o, a);
  endtask

  task automatic t_mabort;
    run_xfer(1'b0, 32'h6000_0000, 3, 0, -1, 1'b1, 0, 0, 2, 0, 6);
    run_xfer(1'b1, 32'h6000_1000, 1, 0, -1, 1'b1, 0, 0, 2, 0, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_write_burst();
    t_read_waits();
    t_single();
    t_stop_reissue();
    t_stop_last();
    t_zero_count();
    t_mabort();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule